// File: doc/BRIEF.md
# FP8 to bfloat16 Widening Converter

This block takes one 8-bit floating-point byte per clock and produces the bfloat16 value it represents. Every 8-bit code fits in bfloat16 with no loss, so the result is exact and no rounding takes place. A format-select input chooses, for each sample, how the byte is read. Code 0 reads it as 1 sign, 5 exponent and 2 fraction bits (exponent bias 15). Code 1 reads it as 1 sign, 4 exponent and 3 fraction bits (exponent bias 7). The block is meant to sit in front of a dot-product datapath and widen compact operands on the fly.

The two formats handle their top exponent differently. The 5-exponent format follows the usual IEEE rules: infinities, plus NaNs for any nonzero fraction. The 4-exponent format has no infinity and uses its top exponent for finite values. Only the all-ones magnitude is NaN in that format. Small (subnormal) inputs are normalized into ordinary bfloat16 normals.

A parameter chooses between two variants: a purely combinational path, or the same path followed by one output register. There is no handshake. A new byte may be presented on every cycle.

Top module: `fp8_bf16_widen`

## Requirements
- R1: With format code 0, a byte whose exponent field is between 1 and 30 produces a bfloat16 exponent equal to that field plus 112. The two fraction bits are placed at the top of the 7-bit bfloat16 fraction and the rest is filled with zeros. The sign is copied.
- R2: With format code 1, a byte whose exponent field is between 1 and 15 is finite, unless its magnitude bits are all ones. It produces the exponent field plus 120, with the three fraction bits placed at the top of the fraction. Magnitude 0x7E (448) gives 0x43E0, or 0xC3E0 when the sign bit is set.
- R3: A byte with a zero exponent field and a nonzero fraction is normalized. The fraction is shifted left until its leading one becomes the hidden bit, and the bfloat16 exponent is lowered by the same amount. Examples: code 0 byte 0x01 gives 0x3780; code 1 byte 0x01 gives 0x3B00; code 1 byte 0x07 gives 0x3C60.
- R4: A zero magnitude keeps its sign: 0x00 gives 0x0000 and 0x80 gives 0x8000 in both formats.
- R5: With format code 0, magnitude 0x7C is infinity and gives 0x7F80, or 0xFF80 when negative.
- R6: Every NaN input gives the quiet NaN 0x7FC0, with the input sign placed in bit 15. With format code 0, NaN means magnitude 0x7D to 0x7F. With format code 1, NaN means magnitude 0x7F only.
- R7: With OUT_REG=1, the output shows the conversion of the byte and format code captured at the previous rising clock edge, and an active-low asynchronous reset clears it to 0x0000. With OUT_REG=0, the output follows the current inputs without delay.
- R8: The format code applies to each sample on its own. The same byte presented on consecutive cycles under different codes yields each code's own result, with no carry-over from the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 1 | 0: 5-exponent/2-fraction format; 1: 4-exponent/3-fraction format |
| fp8_in | input | 8 | Input byte: sign in bit 7 |
| bf16_out | output | 16 | Converted bfloat16 value |

## Verification
In the registered variant, a format switch on the input can coincide with the register still presenting the previous sample's special-value decode. Byte 0x7E is driven under code 0 and then immediately under code 1. Just after the input changes, the registered output must still show the NaN 0x7FC0 while the combinational instance already shows 448 (0x43E0). One edge later the registered output must also read 0x43E0. All 256 codes in both formats are then compared against a reference that evaluates the real number and re-encodes it.

// File: rtl/fp8w_pkg.sv
package fp8w_pkg;

   localparam int BF_EXP_W  = 8;
   localparam int BF_FRAC_W = 7;
   localparam int BF_BIAS   = 127;
   localparam int MAN_W     = 3;  // widest fraction of the two input formats
   localparam int EXP_W     = 5;  // widest exponent of the two input formats
   localparam int WIDE_BIAS = 15;
   localparam int NARR_BIAS = 7;

   typedef enum logic {FMT_WIDE = 1'b0, FMT_NARROW = 1'b1} fp8_fmt_e;

   typedef enum logic [2:0] {
      CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_NAN
   } fp8_cls_e;

   typedef struct packed {
      logic             sign;
      logic [EXP_W-1:0] exp;
      logic [MAN_W-1:0] man;   // left-aligned: narrower fractions padded below
      fp8_cls_e         cls;
   } fp8_fields_t;

   function automatic logic [BF_EXP_W-1:0] rebias(input fp8_fmt_e f);
      return (f == FMT_NARROW) ? BF_EXP_W'(BF_BIAS - NARR_BIAS)
                               : BF_EXP_W'(BF_BIAS - WIDE_BIAS);
   endfunction

endpackage

// File: rtl/fp8w_unpack.sv
module fp8w_unpack
   import fp8w_pkg::*;
(
   input  logic [7:0]  code,
   input  fp8_fmt_e    fmt,
   output fp8_fields_t fld
);
   logic top_exp;
   logic man_zero;

   always_comb begin
      fld.sign = code[7];
      if (fmt == FMT_NARROW) begin
         fld.exp = {1'b0, code[6:3]};
         fld.man = code[2:0];
         top_exp = (code[6:3] == 4'hF);
      end else begin
         fld.exp = code[6:2];
         fld.man = {code[1:0], 1'b0};
         top_exp = (code[6:2] == 5'h1F);
      end
      man_zero = (fld.man == '0);

      if (fld.exp == '0)
         fld.cls = man_zero ? CLS_ZERO : CLS_SUB;
      else if (top_exp && fmt == FMT_WIDE)
         fld.cls = man_zero ? CLS_INF : CLS_NAN;
      else if (top_exp && fld.man == '1)
         fld.cls = CLS_NAN;
      else
         fld.cls = CLS_NORM;
   end
endmodule

// File: rtl/fp8w_subnorm_norm.sv
module fp8w_subnorm_norm #(
   parameter int MW = 3,
   parameter int EW = 8
) (
   input  logic [MW-1:0] man,
   input  logic [EW-1:0] base_exp,
   output logic [MW-1:0] frac,
   output logic [EW-1:0] exp_out
);
   localparam int SW = $clog2(MW + 1);

   logic [SW-1:0] shift;
   logic [MW:0]   wide;

   initial assert (MW >= 1 && EW > SW) else $error("normalizer widths out of range");

   // highest set bit decides the shift; ascending scan lets it win
   always_comb begin
      shift = SW'(MW);
      for (int i = 0; i < MW; i++)
         if (man[i]) shift = SW'(MW - i);
      wide    = {1'b0, man} << shift;
      frac    = wide[MW-1:0];
      exp_out = base_exp - EW'(shift);
   end
endmodule

// File: rtl/fp8w_bf16_pack.sv
module fp8w_bf16_pack
   import fp8w_pkg::*;
(
   input  fp8_fields_t         fld,
   input  logic [BF_EXP_W-1:0] bias_add,
   input  logic [MAN_W-1:0]    sub_frac,
   input  logic [BF_EXP_W-1:0] sub_exp,
   output logic [15:0]         bf16
);
   localparam int PAD = BF_FRAC_W - MAN_W;

   initial assert (PAD >= 0 && 1 + BF_EXP_W + BF_FRAC_W == 16)
      else $error("bfloat16 field widths inconsistent");

   always_comb begin
      unique case (fld.cls)
         CLS_ZERO: bf16 = {fld.sign, 15'h0000};
         CLS_INF:  bf16 = {fld.sign, 15'h7F80};
         CLS_NAN:  bf16 = {fld.sign, 15'h7FC0};
         CLS_SUB:  bf16 = {fld.sign, sub_exp, sub_frac, {PAD{1'b0}}};
         default:  bf16 = {fld.sign,
                           BF_EXP_W'(BF_EXP_W'(fld.exp) + bias_add),
                           fld.man, {PAD{1'b0}}};
      endcase
   end
endmodule

// File: rtl/fp8_bf16_widen.sv
module fp8_bf16_widen
   import fp8w_pkg::*;
#(
   parameter int OUT_REG = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fmt_sel,
   input  logic [7:0]  fp8_in,
   output logic [15:0] bf16_out
);
   initial assert (OUT_REG == 0 || OUT_REG == 1) else $error("OUT_REG must be 0 or 1");

   fp8_fmt_e            fmt;
   fp8_fields_t         fld;
   logic [BF_EXP_W-1:0] bias_add;
   logic [BF_EXP_W-1:0] sub_exp;
   logic [MAN_W-1:0]    sub_frac;
   logic [15:0]         conv;

   assign fmt      = fp8_fmt_e'(fmt_sel);
   assign bias_add = rebias(fmt);

   fp8w_unpack u_unpack (.code(fp8_in), .fmt(fmt), .fld(fld));

   fp8w_subnorm_norm #(.MW(MAN_W), .EW(BF_EXP_W)) u_norm (
      .man      (fld.man),
      .base_exp (bias_add + BF_EXP_W'(1)),
      .frac     (sub_frac),
      .exp_out  (sub_exp)
   );

   fp8w_bf16_pack u_pack (
      .fld(fld), .bias_add(bias_add), .sub_frac(sub_frac),
      .sub_exp(sub_exp), .bf16(conv)
   );

   if (OUT_REG == 1) begin : g_reg
      logic [15:0] q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) q <= '0;
         else        q <= conv;
      assign bf16_out = q;

      a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (fp8_in[6:0] == 7'h00) |=> bf16_out == {$past(fp8_in[7]), 15'h0000});
      a_r5_inf: assert property (@(posedge clk) disable iff (!rst_n)
         (!fmt_sel && fp8_in[6:0] == 7'h7C) |=> bf16_out == {$past(fp8_in[7]), 15'h7F80});
      a_r6_nan: assert property (@(posedge clk) disable iff (!rst_n)
         (fmt_sel && fp8_in[6:0] == 7'h7F) |=> bf16_out == {$past(fp8_in[7]), 15'h7FC0});
      a_r2_max: assert property (@(posedge clk) disable iff (!rst_n)
         (fmt_sel && fp8_in[6:0] == 7'h7E) |=> bf16_out == {$past(fp8_in[7]), 15'h43E0});
   end else begin : g_comb
      assign bf16_out = conv;

      a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (fp8_in[6:0] == 7'h00) |-> bf16_out == {fp8_in[7], 15'h0000});
      a_r5_inf: assert property (@(posedge clk) disable iff (!rst_n)
         (!fmt_sel && fp8_in[6:0] == 7'h7C) |-> bf16_out == {fp8_in[7], 15'h7F80});
      a_r6_nan: assert property (@(posedge clk) disable iff (!rst_n)
         (fmt_sel && fp8_in[6:0] == 7'h7F) |-> bf16_out == {fp8_in[7], 15'h7FC0});
      a_r2_max: assert property (@(posedge clk) disable iff (!rst_n)
         (fmt_sel && fp8_in[6:0] == 7'h7E) |-> bf16_out == {fp8_in[7], 15'h43E0});
   end
endmodule

// File: tb/tb_fp8_bf16_widen.sv
`timescale 1ns/1ps
module tb_fp8_bf16_widen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fmt_sel = 1'b0;
   logic [7:0]  fp8_in = 8'h00;
   logic [15:0] q_out, c_out;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   fp8_bf16_widen #(.OUT_REG(1)) dut (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .fp8_in(fp8_in), .bf16_out(q_out));
   fp8_bf16_widen #(.OUT_REG(0)) dut_c (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .fp8_in(fp8_in), .bf16_out(c_out));

   // {format code, input byte, expected bfloat16}
   localparam logic [24:0] VEC [16] = '{
      {1'b0, 8'h3C, 16'h3F80},  // R1 one
      {1'b0, 8'h7B, 16'h4760},  // R1 largest finite
      {1'b0, 8'h7C, 16'h7F80},  // R5
      {1'b0, 8'hFC, 16'hFF80},  // R5
      {1'b0, 8'h7D, 16'h7FC0},  // R6
      {1'b0, 8'hFF, 16'hFFC0},  // R6
      {1'b0, 8'h01, 16'h3780},  // R3
      {1'b0, 8'h80, 16'h8000},  // R4
      {1'b1, 8'h7E, 16'h43E0},  // R2 448
      {1'b1, 8'hFE, 16'hC3E0},  // R2 -448
      {1'b1, 8'h7F, 16'h7FC0},  // R6
      {1'b1, 8'hFF, 16'hFFC0},  // R6
      {1'b1, 8'h78, 16'h4380},  // R2 top exponent finite
      {1'b1, 8'h01, 16'h3B00},  // R3
      {1'b1, 8'h07, 16'h3C60},  // R3
      {1'b1, 8'h38, 16'h3F80}   // R2 one
   };

   function automatic real pow2(input int k);
      real r = 1.0;
      if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
      else        for (int i = 0; i < -k; i++) r = r / 2.0;
      return r;
   endfunction

   function automatic logic [15:0] ref_bf16(input logic m, input logic [7:0] c);
      logic s = c[7];
      int e, f, mw, bias, top;
      real mag;
      logic [63:0] b;
      if (!m) begin e = int'(c[6:2]); f = int'(c[1:0]); mw = 2; bias = 15; top = 31; end
      else    begin e = int'(c[6:3]); f = int'(c[2:0]); mw = 3; bias = 7;  top = 15; end
      if (!m && e == top) return f == 0 ? {s, 15'h7F80} : {s, 15'h7FC0};
      if (m && e == top && f == 7) return {s, 15'h7FC0};
      if (e == 0 && f == 0) return {s, 15'h0000};
      if (e == 0) mag = real'(f) * pow2(1 - bias - mw);
      else        mag = real'((1 << mw) + f) * pow2(e - bias - mw);
      b = $realtobits(mag);
      return {s, 8'(int'(b[62:52]) - 896), b[51:45]};
   endfunction

   function automatic string req_of(input logic m, input logic [7:0] c);
      if (c[6:0] == 0) return "R4";
      if (!m && c[6:2] == 0) return "R3";
      if (m && c[6:3] == 0) return "R3";
      if (!m && c[6:0] == 7'h7C) return "R5";
      if ((!m && c[6:2] == 5'h1F) || (m && c[6:0] == 7'h7F)) return "R6";
      return m ? "R2" : "R1";
   endfunction

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic apply(input logic m, input logic [7:0] c);
      fmt_sel = m;
      fp8_in  = c;
      @(negedge clk);
   endtask

   initial begin
      fp8_in = 8'h3C;
      repeat (3) @(negedge clk);
      check("R7", "reset clears register", q_out, 16'h0000);
      rst_n = 1'b1;

      foreach (VEC[i]) begin
         apply(VEC[i][24], VEC[i][23:16]);
         check(req_of(VEC[i][24], VEC[i][23:16]), "table reg", q_out, VEC[i][15:0]);
         check(req_of(VEC[i][24], VEC[i][23:16]), "table comb", c_out, VEC[i][15:0]);
      end

      // R8 with R7: format switch while the register still holds the previous NaN
      apply(1'b0, 8'h7E);
      check("R6", "0x7E code 0 reg", q_out, 16'h7FC0);
      fmt_sel = 1'b1;
      #1;
      check("R8", "register still shows previous sample", q_out, 16'h7FC0);
      check("R8", "comb follows new format", c_out, 16'h43E0);
      @(negedge clk);
      check("R8", "register after switch", q_out, 16'h43E0);

      // exhaustive sweep of both formats
      for (int m = 0; m < 2; m++)
         for (int c = 0; c < 256; c++) begin
            apply(m[0], 8'(c));
            check(req_of(m[0], 8'(c)), "sweep reg", q_out, ref_bf16(m[0], 8'(c)));
            check(req_of(m[0], 8'(c)), "sweep comb", c_out, ref_bf16(m[0], 8'(c)));
         end

      // R7: asynchronous reset mid-stream
      apply(1'b0, 8'h3C);
      rst_n = 1'b0;
      #1;
      check("R7", "async reset", q_out, 16'h0000);
      rst_n = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL R7 watchdog: got hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule